// File: doc/BRIEF.md
# Critical-Word-First Line Fill Sequencer

This block refills one cache line over a memory data path that is narrower than the line. A miss request supplies the line number and the index of the 32-bit word that missed. The sequencer then collects the line as a burst of 64-bit beats. The first beat it asks for is the one that holds the missed word, and the burst then wraps around the line. Each beat lands in a line buffer at its real place within the line, whatever order it arrived in.

The missed word goes to the processor side on its own strobe as soon as its beat arrives. The memory path runs much slower than the processor, so this strobe does not wait for the other beats. A one-cycle completion pulse marks the point where the whole line buffer holds valid data.

The memory side sees a byte address for the beat it wants and a ready signal. It answers with a valid signal and the beat data. While a fill is running, the block refuses new miss requests. The beat count per line must be a power of two so that the wrap-around works as a plain counter overflow.

Top module: `cwf_fill_seq`

## Requirements
- R1: After reset, `req_busy`, `mem_ready`, `crit_valid` and `line_done` are low, and `line_data` is all zero.
- R2: When `req_valid` is high while `req_busy` is low, the request is accepted at that clock edge. From the next cycle, `req_busy` and `mem_ready` are high. While idle with `req_valid` low, `req_busy` stays low.
- R3: The first beat address is `{req_line, req_word[2:1], 3'b000}`, so the starting beat is the word index shifted right by one.
- R4: The beat index in `mem_addr[4:3]` takes the values start, start+1, start+2 and start+3 in turn, all mod 4. It advances only at an edge where `mem_valid` and `mem_ready` are both high.
- R5: A beat with index b is stored in `line_data[64*b+63 : 64*b]`. Word w of the line therefore sits at `line_data[32*w+31 : 32*w]`, and an even word is the low half of its beat.
- R6: In the cycle after the first beat is accepted, `crit_valid` is high for exactly one cycle. During that cycle `crit_data` equals the requested word, which is the low half of the beat for an even index and the high half for an odd index. `crit_valid` stays low for all other beats.
- R7: In the cycle after the fourth beat is accepted, `line_done` is high for exactly one cycle and `req_busy` is low. At that point `line_data` holds the whole line.
- R8: A request presented while `req_busy` is high is ignored. The running fill keeps its line number and beat order.
- R9: While idle, `mem_valid` and `mem_data` have no effect: `line_data` is unchanged, and `crit_valid` and `line_done` stay low.
- R10: Cycles with `mem_valid` low during a fill hold `mem_addr` steady and accept no beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Miss request strobe |
| req_line | input | 27 | Line number (byte address bits 31:5) |
| req_word | input | 3 | Index of the missed 32-bit word within the line |
| req_busy | output | 1 | Fill in progress; requests refused |
| mem_ready | output | 1 | Block can take a beat this cycle |
| mem_addr | output | 32 | Byte address of the beat wanted next |
| mem_valid | input | 1 | Memory presents a beat |
| mem_data | input | 64 | Beat data |
| crit_valid | output | 1 | One-cycle strobe for the forwarded missed word |
| crit_data | output | 32 | Forwarded missed word |
| line_data | output | 256 | Line buffer, word w at bits 32w+31:32w |
| line_done | output | 1 | One-cycle pulse after the last beat |

## Verification
The bench targets these cases:
- Starting indices 0 and 7, which exercise the linear order and the wrap-around. A design without the wrap would ask for beat 4, an address outside the line.
- Odd word indices, which expose a design that forwards the wrong half of the beat or stores beats in arrival order instead of at their slot.
- Stall cycles, a second request in the middle of a fill, and stray memory valids while idle. A flawed design would advance the address, adopt the new line, or corrupt the finished buffer.
- A request placed in the very cycle that `line_done` pulses. This catches a design that keeps busy high for one cycle too long.

// File: rtl/cwf_pkg.sv
package cwf_pkg;
    typedef enum logic {
        FILL_IDLE = 1'b0,
        FILL_RUN  = 1'b1
    } fill_mode_e;
endpackage

// File: rtl/cwf_seq.sv
module cwf_seq
    import cwf_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int BEATS  = 4,
    parameter int WPB    = 2,
    parameter int BOFF_W = 3,
    localparam int BIDX_W = $clog2(BEATS),
    localparam int SEL_W  = $clog2(WPB),
    localparam int WIDX_W = BIDX_W + SEL_W,
    localparam int LNUM_W = ADDR_W - BIDX_W - BOFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [LNUM_W-1:0] req_line,
    input  logic [WIDX_W-1:0] req_word,
    input  logic              mem_valid,
    output logic              busy,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              beat_fire,
    output logic              first_fire,
    output logic [BIDX_W-1:0] beat_idx,
    output logic [SEL_W-1:0]  crit_sel,
    output logic              line_done
);
    typedef struct packed {
        fill_mode_e        mode;
        logic [LNUM_W-1:0] line;
        logic [BIDX_W-1:0] cur;
        logic [BIDX_W-1:0] cnt;
        logic [SEL_W-1:0]  sel;
        logic              done;
    } seq_t;

    seq_t seq_d, seq_q;
    logic fire_d;
    logic last_d;

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        fire_d     = (seq_q.mode == FILL_RUN) && mem_valid;
        last_d     = (seq_q.cnt == BIDX_W'(BEATS - 1));
        if (seq_q.mode == FILL_IDLE) begin
            if (req_valid) begin
                seq_d.mode = FILL_RUN;
                seq_d.line = req_line;
                seq_d.cur  = req_word[WIDX_W-1:SEL_W];
                seq_d.sel  = req_word[SEL_W-1:0];
                seq_d.cnt  = '0;
            end
        end else if (fire_d) begin
            seq_d.cur = seq_q.cur + 1'b1;
            seq_d.cnt = seq_q.cnt + 1'b1;
            if (last_d) begin
                seq_d.mode = FILL_IDLE;
                seq_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign busy       = (seq_q.mode == FILL_RUN);
    assign mem_addr   = {seq_q.line, seq_q.cur, {BOFF_W{1'b0}}};
    assign beat_fire  = fire_d;
    assign first_fire = fire_d && (seq_q.cnt == '0);
    assign beat_idx   = seq_q.cur;
    assign crit_sel   = seq_q.sel;
    assign line_done  = seq_q.done;

    assert_addr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !mem_valid) |=> $stable(mem_addr));

    assert_beat_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_fire && !last_d) |=> (beat_idx == BIDX_W'($past(beat_idx) + 1'b1)));

    assert_line_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !(beat_fire && last_d)) |=> $stable(mem_addr[ADDR_W-1:BIDX_W+BOFF_W]));

    assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        line_done |-> (!busy && $past(beat_fire)));
endmodule

// File: rtl/cwf_line_buf.sv
module cwf_line_buf #(
    parameter int BEATS  = 4,
    parameter int BEAT_W = 64,
    localparam int BIDX_W = $clog2(BEATS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [BIDX_W-1:0]       wr_idx,
    input  logic [BEAT_W-1:0]       wr_data,
    output logic [BEATS*BEAT_W-1:0] line_data
);
    for (genvar g = 0; g < BEATS; g++) begin : g_slot
        logic [BEAT_W-1:0] slot_d, slot_q;

        always_comb begin
            slot_d = slot_q;
            if (wr_en && (wr_idx == BIDX_W'(g))) slot_d = wr_data;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) slot_q <= '0;
            else        slot_q <= slot_d;
        end

        assign line_data[g*BEAT_W +: BEAT_W] = slot_q;
    end

    assert_slot_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(line_data));
endmodule

// File: rtl/cwf_crit_fwd.sv
module cwf_crit_fwd #(
    parameter int WORD_W = 32,
    parameter int WPB    = 2,
    localparam int SEL_W  = $clog2(WPB),
    localparam int BEAT_W = WORD_W * WPB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic [SEL_W-1:0]  sel,
    input  logic [BEAT_W-1:0] beat,
    output logic              crit_valid,
    output logic [WORD_W-1:0] crit_data
);
    typedef struct packed {
        logic              vld;
        logic [WORD_W-1:0] data;
    } fwd_t;

    fwd_t fwd_d, fwd_q;

    always_comb begin
        fwd_d     = fwd_q;
        fwd_d.vld = fire;
        if (fire) fwd_d.data = beat[sel*WORD_W +: WORD_W];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fwd_q <= '0;
        else        fwd_q <= fwd_d;
    end

    assign crit_valid = fwd_q.vld;
    assign crit_data  = fwd_q.data;

    assert_crit_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        crit_valid |=> !crit_valid);
endmodule

// File: rtl/cwf_fill_seq.sv
module cwf_fill_seq #(
    parameter int ADDR_W     = 32,
    parameter int WORD_W     = 32,
    parameter int BEAT_W     = 64,
    parameter int LINE_WORDS = 8,
    localparam int WPB       = BEAT_W / WORD_W,
    localparam int BEATS     = LINE_WORDS / WPB,
    localparam int BIDX_W    = $clog2(BEATS),
    localparam int SEL_W     = $clog2(WPB),
    localparam int WIDX_W    = $clog2(LINE_WORDS),
    localparam int BOFF_W    = $clog2(BEAT_W / 8),
    localparam int LNUM_W    = ADDR_W - BIDX_W - BOFF_W,
    localparam int LINE_BITS = LINE_WORDS * WORD_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [LNUM_W-1:0]    req_line,
    input  logic [WIDX_W-1:0]    req_word,
    output logic                 req_busy,
    output logic                 mem_ready,
    output logic [ADDR_W-1:0]    mem_addr,
    input  logic                 mem_valid,
    input  logic [BEAT_W-1:0]    mem_data,
    output logic                 crit_valid,
    output logic [WORD_W-1:0]    crit_data,
    output logic [LINE_BITS-1:0] line_data,
    output logic                 line_done
);
    logic              beat_fire;
    logic              first_fire;
    logic [BIDX_W-1:0] beat_idx;
    logic [SEL_W-1:0]  crit_sel;

    cwf_seq #(
        .ADDR_W (ADDR_W),
        .BEATS  (BEATS),
        .WPB    (WPB),
        .BOFF_W (BOFF_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_line   (req_line),
        .req_word   (req_word),
        .mem_valid  (mem_valid),
        .busy       (req_busy),
        .mem_addr   (mem_addr),
        .beat_fire  (beat_fire),
        .first_fire (first_fire),
        .beat_idx   (beat_idx),
        .crit_sel   (crit_sel),
        .line_done  (line_done)
    );

    cwf_line_buf #(
        .BEATS  (BEATS),
        .BEAT_W (BEAT_W)
    ) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (beat_fire),
        .wr_idx    (beat_idx),
        .wr_data   (mem_data),
        .line_data (line_data)
    );

    cwf_crit_fwd #(
        .WORD_W (WORD_W),
        .WPB    (WPB)
    ) u_fwd (
        .clk        (clk),
        .rst_n      (rst_n),
        .fire       (first_fire),
        .sel        (crit_sel),
        .beat       (mem_data),
        .crit_valid (crit_valid),
        .crit_data  (crit_data)
    );

    assign mem_ready = req_busy;

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        line_done |=> !line_done);

    assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_busy) |-> $past(req_valid));
endmodule

// File: tb/sim_cwf_fill_seq.sv
module sim_cwf_fill_seq;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic [26:0]  req_line = '0;
    logic [2:0]   req_word = '0;
    logic         req_busy;
    logic         mem_ready;
    logic [31:0]  mem_addr;
    logic         mem_valid = 1'b0;
    logic [63:0]  mem_data = '0;
    logic         crit_valid;
    logic [31:0]  crit_data;
    logic [255:0] line_data;
    logic         line_done;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cwf_fill_seq u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_line   (req_line),
        .req_word   (req_word),
        .req_busy   (req_busy),
        .mem_ready  (mem_ready),
        .mem_addr   (mem_addr),
        .mem_valid  (mem_valid),
        .mem_data   (mem_data),
        .crit_valid (crit_valid),
        .crit_data  (crit_data),
        .line_data  (line_data),
        .line_done  (line_done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] wv(input logic [26:0] ln, input int w);
        return ({ln, 5'b0} | (32'(w) << 2)) ^ 32'h5A5A_0000;
    endfunction

    function automatic logic [63:0] bv(input logic [26:0] ln, input int b);
        return {wv(ln, 2*b+1), wv(ln, 2*b)};
    endfunction

    function automatic logic [255:0] lv(input logic [26:0] ln);
        logic [255:0] r;
        for (int w = 0; w < 8; w++) r[32*w +: 32] = wv(ln, w);
        return r;
    endfunction

    task automatic t_reset();
        chk(req_busy == 1'b0, "R1", "busy", 256'(req_busy), 0);
        chk(mem_ready == 1'b0, "R1", "mem_ready", 256'(mem_ready), 0);
        chk(crit_valid == 1'b0, "R1", "crit_valid", 256'(crit_valid), 0);
        chk(line_done == 1'b0, "R1", "line_done", 256'(line_done), 0);
        chk(line_data == '0, "R1", "line_data", line_data, 0);
        @(negedge clk);
        chk(req_busy == 1'b0, "R2", "idle busy without request", 256'(req_busy), 0);
    endtask

    task automatic t_fill(input logic [26:0] ln, input logic [2:0] wd,
                          input int gap, input bit intrude);
        int start;
        start = int'(wd) >> 1;
        req_valid = 1'b1; req_line = ln; req_word = wd;
        @(negedge clk);
        req_valid = 1'b0; req_line = ~ln; req_word = ~wd;
        chk(req_busy == 1'b1, "R2", "busy after accept", 256'(req_busy), 1);
        chk(mem_ready == 1'b1, "R2", "mem_ready after accept", 256'(mem_ready), 1);
        chk(line_done == 1'b0, "R7", "done not held", 256'(line_done), 0);
        for (int k = 0; k < 4; k++) begin
            logic [1:0]  eb;
            logic [31:0] ea;
            eb = 2'((start + k) % 4);
            ea = {ln, eb, 3'b000};
            if (intrude && k == 1) begin
                req_valid = 1'b1; req_line = ln ^ 27'h155; req_word = ~wd;
                @(negedge clk);
                req_valid = 1'b0;
                chk(mem_addr == ea, "R8", "addr after refused request", 256'(mem_addr), 256'(ea));
                chk(req_busy == 1'b1, "R8", "busy kept", 256'(req_busy), 1);
            end
            for (int g = 0; g < gap; g++) begin
                mem_valid = 1'b0; mem_data = 64'hDEAD_BEEF_0BAD_F00D;
                @(negedge clk);
                chk(mem_addr == ea, "R10", "addr during stall", 256'(mem_addr), 256'(ea));
            end
            chk(mem_addr == ea, (k == 0) ? "R3" : "R4", "beat addr", 256'(mem_addr), 256'(ea));
            mem_valid = 1'b1; mem_data = bv(ln, int'(eb));
            @(negedge clk);
            mem_valid = 1'b0; mem_data = '0;
            if (k == 0) begin
                chk(crit_valid == 1'b1, "R6", "crit strobe", 256'(crit_valid), 1);
                chk(crit_data == wv(ln, int'(wd)), "R6", "crit word",
                    256'(crit_data), 256'(wv(ln, int'(wd))));
            end else begin
                chk(crit_valid == 1'b0, "R6", "no crit on later beat", 256'(crit_valid), 0);
            end
            if (k < 3) begin
                chk(line_done == 1'b0, "R7", "early done", 256'(line_done), 0);
            end else begin
                chk(line_done == 1'b1, "R7", "done pulse", 256'(line_done), 1);
                chk(req_busy == 1'b0, "R7", "busy cleared", 256'(req_busy), 0);
                chk(line_data == lv(ln), "R5", "line contents", line_data, lv(ln));
            end
        end
    endtask

    task automatic t_idle_noise();
        logic [255:0] held;
        @(negedge clk);
        chk(line_done == 1'b0, "R7", "done one cycle", 256'(line_done), 0);
        held = line_data;
        for (int i = 0; i < 3; i++) begin
            mem_valid = 1'b1; mem_data = 64'h0123_4567_89AB_CDEF ^ 64'(i);
            @(negedge clk);
            chk(crit_valid == 1'b0, "R9", "idle crit", 256'(crit_valid), 0);
            chk(mem_ready == 1'b0, "R9", "idle ready", 256'(mem_ready), 0);
        end
        mem_valid = 1'b0;
        chk(line_data == held, "R9", "idle line kept", line_data, held);
        chk(line_done == 1'b0, "R9", "idle done", 256'(line_done), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_fill(27'h0001234, 3'd0, 0, 1'b0);
        t_fill(27'h7ABCDEF, 3'd7, 0, 1'b0);
        t_fill(27'h0055AA0, 3'd3, 2, 1'b0);
        t_fill(27'h1234567, 3'd4, 1, 1'b1);
        t_fill(27'h0F0F0F0, 3'd5, 0, 1'b0);
        t_fill(27'h3C3C3C3, 3'd2, 0, 1'b0);
        t_idle_noise();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule